// File: doc/BRIEF.md
# Shadowed LCD Timing Generator

This block scans a parallel RGB panel. It produces horizontal sync, vertical sync, a data-enable strobe, a pixel-clock strobe and the X/Y coordinates of the current active pixel. All porch, sync-width and active-size settings enter as minus-one values. The block holds those inputs as the pending (shadow) set and copies them into its own working registers only at a frame boundary. While the protect input is high, that copy is skipped. Software can therefore rewrite several fields in any order without the scan ever using a half-updated configuration.

A pixel-rate divider produces one strobe every N system cycles, with N from 1 to 256, and all counting advances on that strobe. The divider settings are shadowed with the timing. A frame interrupt sets a sticky pending flag when the vertical sync pulse begins. A write-one pulse clears the flag, and two enables gate it onto the interrupt line. The master video enable is part of the shadow set. When the block is idle and unprotected, the working set follows the inputs on every cycle. Once the block runs, a stop takes effect only at the end of the current frame.

Top module: `lcd_timing_gen`

## Requirements
- R1: During and after reset, with all polarity bits clear, every output is low and the scan is idle. The outputs are the syncs, data enable, X/Y, pending and interrupt.
- R2: A line lasts (hsw+1)+(hbp+1)+(hact+1)+(hfp+1) pixel strobes, in the order sync, back porch, active, front porch. The raw hsync is high for exactly the first hsw+1 strobes.
- R3: A frame lasts (vsw+1)+(vbp+1)+(vact+1)+(vfp+1) lines in the same order. The raw vsync is high for the first vsw+1 lines.
- R4: The raw data enable is high only where the horizontal and vertical active regions overlap. There x_o and y_o count from 0 up to hact and vact; elsewhere both read 0.
- R5: pol_inv_i inverts outputs immediately and without shadowing: bit 0 inverts hsync_o, bit 1 vsync_o, bit 2 de_o and bit 3 pclk_o.
- R6: While the scan runs, a changed timing input takes effect only at the end of the last pixel of the frame. The next frame then starts at the sync position.
- R7: While protect_i is high at a frame boundary, the working set is kept. Pending inputs transfer at the first boundary that is reached with protect_i low.
- R8: With div_en_i low, pclk_en_o is high every cycle. With div_en_i high, pclk_en_o is high once every div_val_i+1 cycles (up to 256). Counters advance only on that strobe.
- R9: vid_en_i is shadowed. When the scan is idle and unprotected, it starts at the sync position one cycle after vid_en_i is seen high. Clearing vid_en_i stops the scan at the next frame boundary, and the raw outputs then stay inactive.
- R10: With irq_sel_i high, irq_pend_o sets on the clock edge that ends the first cycle of the vsync pulse. A high irq_clr_i clears it, and a set in the same cycle wins. With irq_sel_i low, the flag never sets.
- R11: irq_o is high exactly when irq_pend_o, irq_en_i and irq_frame_en_i are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vid_en_i | input | 1 | Pending master video enable |
| protect_i | input | 1 | Blocks the shadow transfer while high |
| hsw_i | input | H_W | Hsync width minus one |
| hbp_i | input | H_W | Horizontal back porch minus one |
| hact_i | input | H_W | Active width minus one |
| hfp_i | input | H_W | Horizontal front porch minus one |
| vsw_i | input | V_W | Vsync width in lines minus one |
| vbp_i | input | V_W | Vertical back porch minus one |
| vact_i | input | V_W | Active height minus one |
| vfp_i | input | V_W | Vertical front porch minus one |
| div_en_i | input | 1 | Selects divided pixel rate |
| div_val_i | input | DIV_W | Divide ratio minus one |
| pol_inv_i | input | 4 | Output inversions, bits listed in R5 |
| irq_en_i | input | 1 | Global interrupt enable |
| irq_frame_en_i | input | 1 | Frame interrupt enable |
| irq_sel_i | input | 1 | 1 selects vsync start as the event, 0 selects none |
| irq_clr_i | input | 1 | Write-one clear of the pending flag |
| pclk_en_o | output | 1 | Pixel strobe, one system cycle wide |
| pclk_o | output | 1 | Pixel strobe after polarity control |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| x_o | output | H_W | Active column |
| y_o | output | V_W | Active row |
| irq_pend_o | output | 1 | Frame interrupt pending |
| irq_o | output | 1 | Frame interrupt request |

## Verification
Some rules hold on every cycle, and the assertions check those. The protect input freezes the working set, and a running scan changes configuration only at a frame boundary. The counters hold between pixel strobes, the divider count stays within its ratio, and data enable never overlaps a sync pulse or appears while idle. The pending flag follows its set and clear rules. Other properties can only be shown by the bench's scenarios driven against its reference model. These are the exact pulse widths and active extents, the deferred take-up of a mid-frame change or of a lifted protect, the divide ratios at both ends of the range, the stop at the end of a frame, and the idle levels under inversion.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int unsigned POL_HSYNC = 0;
  localparam int unsigned POL_VSYNC = 1;
  localparam int unsigned POL_DE    = 2;
  localparam int unsigned POL_PCLK  = 3;
  localparam int unsigned POL_N     = 4;
endpackage

// File: rtl/lcd_tg_shadow.sv
module lcd_tg_shadow #(
  parameter int unsigned H_W   = 12,
  parameter int unsigned V_W   = 12,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             protect_i,
  input  logic             frame_end_i,
  input  logic             sh_run_i,
  input  logic [H_W-1:0]   sh_hsw_i,
  input  logic [H_W-1:0]   sh_hbp_i,
  input  logic [H_W-1:0]   sh_hact_i,
  input  logic [H_W-1:0]   sh_hfp_i,
  input  logic [V_W-1:0]   sh_vsw_i,
  input  logic [V_W-1:0]   sh_vbp_i,
  input  logic [V_W-1:0]   sh_vact_i,
  input  logic [V_W-1:0]   sh_vfp_i,
  input  logic             sh_div_en_i,
  input  logic [DIV_W-1:0] sh_div_val_i,
  output logic             run_o,
  output logic [H_W-1:0]   hsw_o,
  output logic [H_W-1:0]   hbp_o,
  output logic [H_W-1:0]   hact_o,
  output logic [H_W-1:0]   hfp_o,
  output logic [V_W-1:0]   vsw_o,
  output logic [V_W-1:0]   vbp_o,
  output logic [V_W-1:0]   vact_o,
  output logic [V_W-1:0]   vfp_o,
  output logic             div_en_o,
  output logic [DIV_W-1:0] div_val_o,
  output logic             load_o
);
  // idle scan reloads every cycle; running scan only at frame end
  assign load_o = !protect_i && (!run_o || frame_end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0; div_en_o <= 1'b0; div_val_o <= '0;
      hsw_o <= '0; hbp_o <= '0; hact_o <= '0; hfp_o <= '0;
      vsw_o <= '0; vbp_o <= '0; vact_o <= '0; vfp_o <= '0;
    end else if (load_o) begin
      run_o <= sh_run_i; div_en_o <= sh_div_en_i; div_val_o <= sh_div_val_i;
      hsw_o <= sh_hsw_i; hbp_o <= sh_hbp_i; hact_o <= sh_hact_i; hfp_o <= sh_hfp_i;
      vsw_o <= sh_vsw_i; vbp_o <= sh_vbp_i; vact_o <= sh_vact_i; vfp_o <= sh_vfp_i;
    end
  end

  // R7
  protect_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protect_i |=> $stable({run_o, div_en_o, div_val_o, hsw_o, hbp_o, hact_o, hfp_o,
                           vsw_o, vbp_o, vact_o, vfp_o}));
  // R6
  boundary_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !frame_end_i) |=> $stable({run_o, div_en_o, div_val_o, hsw_o, hbp_o,
                                         hact_o, hfp_o, vsw_o, vbp_o, vact_o, vfp_o}));
endmodule

// File: rtl/lcd_tg_pixdiv.sv
module lcd_tg_pixdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_en_i,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic             load_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = !div_en_i || (cnt_q == div_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (tick_o || load_i)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R8
  div_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_val_i);
endmodule

// File: rtl/lcd_tg_scan.sv
module lcd_tg_scan #(
  parameter int unsigned H_W = 12,
  parameter int unsigned V_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           tick_i,
  input  logic [H_W-1:0] hsw_i,
  input  logic [H_W-1:0] hbp_i,
  input  logic [H_W-1:0] hact_i,
  input  logic [H_W-1:0] hfp_i,
  input  logic [V_W-1:0] vsw_i,
  input  logic [V_W-1:0] vbp_i,
  input  logic [V_W-1:0] vact_i,
  input  logic [V_W-1:0] vfp_i,
  output logic           frame_end_o,
  output logic           origin_o,
  output logic           hs_raw_o,
  output logic           vs_raw_o,
  output logic           de_raw_o,
  output logic [H_W-1:0] x_o,
  output logic [V_W-1:0] y_o
);
  localparam int unsigned HC_W = H_W + 2;
  localparam int unsigned VC_W = V_W + 2;

  logic [HC_W-1:0] h_q, h_last, h_beg, h_end, h_sw;
  logic [VC_W-1:0] v_q, v_last, v_beg, v_end, v_sw;
  logic            at_h_last, at_v_last, h_act, v_act;

  assign h_sw   = HC_W'(hsw_i);
  assign h_beg  = h_sw + HC_W'(hbp_i) + HC_W'(2);
  assign h_end  = h_beg + HC_W'(hact_i);
  assign h_last = h_end + HC_W'(hfp_i) + HC_W'(1);
  assign v_sw   = VC_W'(vsw_i);
  assign v_beg  = v_sw + VC_W'(vbp_i) + VC_W'(2);
  assign v_end  = v_beg + VC_W'(vact_i);
  assign v_last = v_end + VC_W'(vfp_i) + VC_W'(1);

  assign at_h_last   = (h_q == h_last);
  assign at_v_last   = (v_q == v_last);
  assign frame_end_o = run_i && tick_i && at_h_last && at_v_last;
  assign origin_o    = run_i && (h_q == '0) && (v_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0; v_q <= '0;
    end else if (!run_i) begin
      h_q <= '0; v_q <= '0;
    end else if (tick_i) begin
      if (at_h_last) begin
        h_q <= '0;
        v_q <= at_v_last ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  assign h_act    = (h_q >= h_beg) && (h_q <= h_end);
  assign v_act    = (v_q >= v_beg) && (v_q <= v_end);
  assign hs_raw_o = run_i && (h_q <= h_sw);
  assign vs_raw_o = run_i && (v_q <= v_sw);
  assign de_raw_o = run_i && h_act && v_act;
  assign x_o      = de_raw_o ? H_W'(h_q - h_beg) : '0;
  assign y_o      = de_raw_o ? V_W'(v_q - v_beg) : '0;

  // R8
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> ($stable(h_q) && $stable(v_q)));
  // R2
  h_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_q <= h_last);
endmodule

// File: rtl/lcd_tg_irq.sv
module lcd_tg_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic origin_i,
  input  logic sel_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic frm_en_i,
  output logic pend_o,
  output logic irq_o
);
  logic org_q, evt;

  assign evt = sel_i && origin_i && !org_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      org_q <= 1'b0; pend_o <= 1'b0;
    end else begin
      org_q <= origin_i;
      if (evt)        pend_o <= 1'b1;
      else if (clr_i) pend_o <= 1'b0;
    end
  end

  assign irq_o = pend_o && en_i && frm_en_i;

  // R10
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> pend_o);
  // R10
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt) |=> !pend_o);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int unsigned H_W   = 12,
  parameter int unsigned V_W   = 12,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vid_en_i,
  input  logic             protect_i,
  input  logic [H_W-1:0]   hsw_i,
  input  logic [H_W-1:0]   hbp_i,
  input  logic [H_W-1:0]   hact_i,
  input  logic [H_W-1:0]   hfp_i,
  input  logic [V_W-1:0]   vsw_i,
  input  logic [V_W-1:0]   vbp_i,
  input  logic [V_W-1:0]   vact_i,
  input  logic [V_W-1:0]   vfp_i,
  input  logic             div_en_i,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic [POL_N-1:0] pol_inv_i,
  input  logic             irq_en_i,
  input  logic             irq_frame_en_i,
  input  logic             irq_sel_i,
  input  logic             irq_clr_i,
  output logic             pclk_en_o,
  output logic             pclk_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [H_W-1:0]   x_o,
  output logic [V_W-1:0]   y_o,
  output logic             irq_pend_o,
  output logic             irq_o
);
  logic             run, div_en, load, tick, frame_end, origin;
  logic             hs_raw, vs_raw, de_raw;
  logic [DIV_W-1:0] div_val;
  logic [H_W-1:0]   hsw, hbp, hact, hfp;
  logic [V_W-1:0]   vsw, vbp, vact, vfp;

  lcd_tg_shadow #(.H_W(H_W), .V_W(V_W), .DIV_W(DIV_W)) i_shadow (
    .clk_i, .rst_ni, .protect_i, .frame_end_i(frame_end),
    .sh_run_i(vid_en_i), .sh_hsw_i(hsw_i), .sh_hbp_i(hbp_i), .sh_hact_i(hact_i),
    .sh_hfp_i(hfp_i), .sh_vsw_i(vsw_i), .sh_vbp_i(vbp_i), .sh_vact_i(vact_i),
    .sh_vfp_i(vfp_i), .sh_div_en_i(div_en_i), .sh_div_val_i(div_val_i),
    .run_o(run), .hsw_o(hsw), .hbp_o(hbp), .hact_o(hact), .hfp_o(hfp),
    .vsw_o(vsw), .vbp_o(vbp), .vact_o(vact), .vfp_o(vfp),
    .div_en_o(div_en), .div_val_o(div_val), .load_o(load)
  );

  lcd_tg_pixdiv #(.DIV_W(DIV_W)) i_pixdiv (
    .clk_i, .rst_ni, .div_en_i(div_en), .div_val_i(div_val), .load_i(load),
    .tick_o(tick)
  );

  lcd_tg_scan #(.H_W(H_W), .V_W(V_W)) i_scan (
    .clk_i, .rst_ni, .run_i(run), .tick_i(tick),
    .hsw_i(hsw), .hbp_i(hbp), .hact_i(hact), .hfp_i(hfp),
    .vsw_i(vsw), .vbp_i(vbp), .vact_i(vact), .vfp_i(vfp),
    .frame_end_o(frame_end), .origin_o(origin),
    .hs_raw_o(hs_raw), .vs_raw_o(vs_raw), .de_raw_o(de_raw), .x_o, .y_o
  );

  lcd_tg_irq i_irq (
    .clk_i, .rst_ni, .origin_i(origin), .sel_i(irq_sel_i), .clr_i(irq_clr_i),
    .en_i(irq_en_i), .frm_en_i(irq_frame_en_i), .pend_o(irq_pend_o), .irq_o
  );

  assign pclk_en_o = tick;
  assign pclk_o    = tick   ^ pol_inv_i[POL_PCLK];
  assign hsync_o   = hs_raw ^ pol_inv_i[POL_HSYNC];
  assign vsync_o   = vs_raw ^ pol_inv_i[POL_VSYNC];
  assign de_o      = de_raw ^ pol_inv_i[POL_DE];

  // R4
  de_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_raw |-> (!hs_raw && !vs_raw));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!de_raw && !hs_raw && !vs_raw));
endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic vid_en_i = 1'b0, protect_i = 1'b0;
  logic [11:0] hsw_i = '0, hbp_i = '0, hact_i = '0, hfp_i = '0;
  logic [11:0] vsw_i = '0, vbp_i = '0, vact_i = '0, vfp_i = '0;
  logic div_en_i = 1'b0;
  logic [7:0] div_val_i = '0;
  logic [3:0] pol_inv_i = '0;
  logic irq_en_i = 1'b0, irq_frame_en_i = 1'b0, irq_sel_i = 1'b0, irq_clr_i = 1'b0;
  logic pclk_en_o, pclk_o, hsync_o, vsync_o, de_o, irq_pend_o, irq_o;
  logic [11:0] x_o, y_o;

  always #10 clk_i = ~clk_i;

  lcd_timing_gen i_lcd_timing_gen (
    .clk_i, .rst_ni, .vid_en_i, .protect_i, .hsw_i, .hbp_i, .hact_i, .hfp_i,
    .vsw_i, .vbp_i, .vact_i, .vfp_i, .div_en_i, .div_val_i, .pol_inv_i,
    .irq_en_i, .irq_frame_en_i, .irq_sel_i, .irq_clr_i, .pclk_en_o, .pclk_o,
    .hsync_o, .vsync_o, .de_o, .x_o, .y_o, .irq_pend_o, .irq_o
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  string cur_tag = "R1";

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s (scenario %s) act=%0d exp=%0d", req, what, cur_tag, act, exp);
    end
  endtask

  // behavioural reference: working set, position, divider, interrupt
  int m_run, m_hsw, m_hbp, m_hact, m_hfp, m_vsw, m_vbp, m_vact, m_vfp, m_den, m_dval;
  int m_h, m_v, m_cnt, m_pend, m_porg;

  always @(posedge clk_i or negedge rst_ni) begin : mdl
    int line_len, frame_lines;
    bit tk, fend, org, ld;
    if (!rst_ni) begin
      m_run = 0; m_hsw = 0; m_hbp = 0; m_hact = 0; m_hfp = 0;
      m_vsw = 0; m_vbp = 0; m_vact = 0; m_vfp = 0; m_den = 0; m_dval = 0;
      m_h = 0; m_v = 0; m_cnt = 0; m_pend = 0; m_porg = 0;
    end else begin
      line_len    = m_hsw + m_hbp + m_hact + m_hfp + 4;
      frame_lines = m_vsw + m_vbp + m_vact + m_vfp + 4;
      tk   = (m_den == 0) || (m_cnt == m_dval);
      fend = m_run != 0 && tk && m_h == line_len - 1 && m_v == frame_lines - 1;
      org  = m_run != 0 && m_h == 0 && m_v == 0;
      if (irq_sel_i && org && m_porg == 0) m_pend = 1;
      else if (irq_clr_i) m_pend = 0;
      m_porg = org;
      ld = !protect_i && (m_run == 0 || fend);
      m_cnt = (tk || ld) ? 0 : m_cnt + 1;
      if (m_run == 0) begin m_h = 0; m_v = 0; end
      else if (tk) begin
        m_h++;
        if (m_h == line_len) begin
          m_h = 0; m_v++;
          if (m_v == frame_lines) m_v = 0;
        end
      end
      if (ld) begin
        m_run = int'(vid_en_i); m_den = int'(div_en_i); m_dval = int'(div_val_i);
        m_hsw = int'(hsw_i); m_hbp = int'(hbp_i); m_hact = int'(hact_i); m_hfp = int'(hfp_i);
        m_vsw = int'(vsw_i); m_vbp = int'(vbp_i); m_vact = int'(vact_i); m_vfp = int'(vfp_i);
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) if (!done) begin : cmp
    int hb, vb, ex, ey;
    bit ehs, evs, ede, etk;
    hb  = m_hsw + m_hbp + 2;
    vb  = m_vsw + m_vbp + 2;
    etk = (m_den == 0) || (m_cnt == m_dval);
    ehs = m_run != 0 && m_h < m_hsw + 1;
    evs = m_run != 0 && m_v < m_vsw + 1;
    ede = m_run != 0 && m_h >= hb && m_h <= hb + m_hact && m_v >= vb && m_v <= vb + m_vact;
    ex  = ede ? m_h - hb : 0;
    ey  = ede ? m_v - vb : 0;
    chk("R2", int'(hsync_o), int'(ehs ^ pol_inv_i[0]), "hsync");
    chk("R3", int'(vsync_o), int'(evs ^ pol_inv_i[1]), "vsync");
    chk("R4", int'(de_o), int'(ede ^ pol_inv_i[2]), "de");
    chk("R4", int'(x_o), ex, "x");
    chk("R4", int'(y_o), ey, "y");
    chk("R8", int'(pclk_en_o), int'(etk), "pclk_en");
    chk("R5", int'(pclk_o), int'(etk ^ pol_inv_i[3]), "pclk");
    chk("R10", int'(irq_pend_o), m_pend, "pend");
    chk("R11", int'(irq_o), int'(m_pend != 0 && irq_en_i && irq_frame_en_i), "irq");
  end

  // scenario monitors
  int hs_len = 0, last_hs = 0, vs_len = 0, last_vs = 0, max_x = 0, max_y = 0;
  int gcnt = 0, last_gap = 0;
  always @(negedge clk_i) begin
    if (hsync_o) hs_len++; else if (hs_len > 0) begin last_hs = hs_len; hs_len = 0; end
    if (vsync_o) vs_len++; else if (vs_len > 0) begin last_vs = vs_len; vs_len = 0; end
    if (de_o && int'(x_o) > max_x) max_x = int'(x_o);
    if (de_o && int'(y_o) > max_y) max_y = int'(y_o);
    if (pclk_en_o) begin last_gap = gcnt + 1; gcnt = 0; end else gcnt++;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    cur_tag = "R1";
    repeat (3) @(negedge clk_i);
    chk("R1", int'({hsync_o, vsync_o, de_o, irq_pend_o, irq_o}), 0, "outputs in reset");
    chk("R1", int'({x_o, y_o}), 0, "xy in reset");
    wait_cyc(1);
    rst_ni = 1'b1;
    hsw_i = 1; hbp_i = 1; hact_i = 3; hfp_i = 1;
    vsw_i = 0; vbp_i = 1; vact_i = 2; vfp_i = 0;
    wait_cyc(3);
    @(negedge clk_i);
    chk("R1", int'({hsync_o, vsync_o, de_o, irq_pend_o, irq_o}), 0, "idle after reset");

    // R2 R3 R4 R9: start and run full frames
    cur_tag = "R9";
    irq_en_i = 1; irq_frame_en_i = 1; irq_sel_i = 1;
    wait_cyc(1);
    vid_en_i = 1;
    wait_cyc(150);
    @(negedge clk_i);
    chk("R2", last_hs, 2, "hsync pulse cycles");
    chk("R3", last_vs, 10, "vsync pulse cycles");
    chk("R4", max_x, 3, "max x");
    chk("R4", max_y, 2, "max y");

    // R10: clear pending after it sets
    cur_tag = "R10";
    @(posedge vsync_o);
    wait_cyc(5);
    chk("R10", int'(irq_pend_o), 1, "pending after vsync");
    irq_clr_i = 1;
    wait_cyc(1);
    irq_clr_i = 0;
    @(negedge clk_i);
    chk("R10", int'(irq_pend_o), 0, "pending after clear");

    // R11: enable gating
    cur_tag = "R11";
    wait_cyc(1);
    irq_en_i = 0;
    @(posedge vsync_o);
    wait_cyc(3);
    @(negedge clk_i);
    chk("R11", int'(irq_o), 0, "irq with global enable off");
    wait_cyc(1);
    irq_en_i = 1;
    @(negedge clk_i);
    chk("R11", int'(irq_o), 1, "irq with both enables");

    // R6: mid-frame change waits for boundary
    cur_tag = "R6";
    @(posedge vsync_o);
    wait_cyc(20);
    hact_i = 5; max_x = 0;
    wait_cyc(30);
    @(negedge clk_i);
    chk("R6", max_x, 3, "width before boundary");

    // R7: protect holds, release loads
    cur_tag = "R7";
    wait_cyc(1);
    protect_i = 1; max_x = 0;
    wait_cyc(200);
    @(negedge clk_i);
    chk("R7", max_x, 3, "width while protected");
    wait_cyc(1);
    protect_i = 0; max_x = 0;
    wait_cyc(200);
    @(negedge clk_i);
    chk("R7", max_x, 5, "width after release");

    // R5: inversions while running
    cur_tag = "R5";
    wait_cyc(1);
    pol_inv_i = 4'b0111;
    wait_cyc(100);
    pol_inv_i = 4'b0000;

    // R8: divider ratios
    cur_tag = "R8";
    wait_cyc(1);
    div_en_i = 1; div_val_i = 2;
    wait_cyc(200);
    @(negedge clk_i);
    chk("R8", last_gap, 3, "strobe gap ratio 3");
    wait_cyc(1);
    div_val_i = 255;
    wait_cyc(800);
    @(negedge clk_i);
    chk("R8", last_gap, 256, "strobe gap ratio 256");
    wait_cyc(1);
    div_en_i = 0; div_val_i = 0;
    wait_cyc(22000);
    @(negedge clk_i);
    chk("R8", last_gap, 1, "undivided strobe");

    // R10: selector off never sets
    cur_tag = "R10";
    wait_cyc(1);
    irq_sel_i = 0; irq_clr_i = 1;
    wait_cyc(1);
    irq_clr_i = 0;
    wait_cyc(200);
    @(negedge clk_i);
    chk("R10", int'(irq_pend_o), 0, "no event with selector off");
    wait_cyc(1);
    irq_sel_i = 1;

    // R9: stop at frame end
    cur_tag = "R9";
    vid_en_i = 0;
    wait_cyc(100);
    begin
      int act_seen;
      act_seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk_i);
        if (hsync_o || vsync_o || de_o) act_seen++;
      end
      chk("R9", act_seen, 0, "active cycles after stop");
    end

    // R5: idle levels under full inversion
    cur_tag = "R5";
    wait_cyc(1);
    pol_inv_i = 4'hF;
    @(negedge clk_i);
    chk("R5", int'({hsync_o, vsync_o, de_o, pclk_o}), 4'b1110, "inverted idle levels");
    wait_cyc(5);
    finish_run();
  end
endmodule